// File: doc/BRIEF.md
# Multi-Window Card Address Decoder

This block sits between a host bus and a 16-bit card socket controller. It compares each host request address against eight programmable windows and picks the one that covers it. Every window has a base register and an option register, both written by software. The option register carries the fields that the card access needs: the socket, the address space (common memory, attribute memory or I/O), the bus width, write protection, three access-timing fields and a size code.

The block has no offset register. The card-side offset is therefore the host address minus the window base. A request that lands in an enabled window produces a one-cycle access strobe one clock later. The strobe carries the window number, the offset and the decoded fields. A write that lands in a write-protected window is not forwarded. Instead it raises a one-cycle error pulse. The card strobe sequencing, bus timeout handling and socket power are left to neighbouring logic.

Top module: `card_win_decoder`

## Requirements
- R1: After reset every window is disabled: `acc_valid` and `wp_err` are 0, and no request produces a strobe until a window has been configured.
- R2: A request with `req_valid` high whose address satisfies base <= address < base + size of an enabled window gives `acc_valid` high for exactly the following clock cycle. In that cycle `acc_idx` is the window number and `acc_offset` is the address minus the base.
- R3: Option register bit fields: bit 0 valid, bit 1 write-protect, bit 2 socket (`acc_slot`). Bits [4:3] select the space: 2'b10 is attribute, 2'b11 is I/O, and 2'b00 or 2'b01 is common memory, which is reported on `acc_space` as 2'b00. Bit 6 selects the 16-bit bus (`acc_wide`). Bits [10:7] are `acc_hold`, bits [14:11] are `acc_setup` and bits [20:15] are `acc_strobe`.
- R4: Option bits [31:27] hold the size code, which is the Gray code of log2(size). A code whose decoded exponent exceeds 26 disables the window; codes 16 to 19 and 22 are such codes. The largest legal window is 64 MB.
- R5: A window whose valid bit is 0 never matches. Writing the option register to zero disables the window.
- R6: A memory window (space not I/O) whose base has any of bits [11:0] set never matches. This enforces the 4 KB boundary.
- R7: An I/O window whose size exceeds 64 KB (exponent above 16) never matches. Hence every I/O access has an offset below 65536. An I/O window base needs no 4 KB alignment.
- R8: When several enabled windows cover the address, the lowest-numbered one is reported.
- R9: A write (`req_write` high) to a write-protected window gives `wp_err` high for one cycle and no `acc_valid`. A read of the same window hits normally.
- R10: A configuration write in the same cycle as a request does not affect that request, which is decoded against the previous settings. The new settings apply from the next cycle on.
- R11: A cycle with `req_valid` low, or a request that matches no window, gives neither `acc_valid` nor `wp_err` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel_opt | input | 1 | 1 writes the option register, 0 writes the base register |
| cfg_idx | input | IDX_W (3) | Window number being written |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | Host request is a write |
| req_addr | input | ADDR_W (32) | Host request address |
| acc_valid | output | 1 | One-cycle access strobe for a decoded hit |
| acc_idx | output | IDX_W (3) | Number of the winning window |
| acc_offset | output | ADDR_W (32) | Card-side offset (address minus base) |
| acc_slot | output | 1 | Socket of the winning window |
| acc_space | output | 2 | 00 common, 10 attribute, 11 I/O |
| acc_wide | output | 1 | 16-bit bus access |
| acc_hold | output | 4 | Hold time field |
| acc_setup | output | 4 | Setup time field |
| acc_strobe | output | 6 | Strobe length field |
| wp_err | output | 1 | One-cycle pulse for a blocked write to a protected window |

## Verification
A configuration write and a host decode can fall in the same clock cycle, including a write that disables the very window the request hits. The bench provokes this by raising `cfg_we` with a zero option value for window 2 on the same edge that a read of window 2 is presented. It expects that read to hit window 2 with the old settings. An identical read on the following cycle must then miss. The two outcomes together show that the decoder reads the registered settings and that the write takes effect exactly one cycle later.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int OPT_W       = 32;
    localparam int SIZE_CODE_W = 5;
    localparam int MAX_LOG2    = 26;

    typedef enum logic [1:0] {
        SPC_COMMON = 2'b00,
        SPC_ALIAS  = 2'b01,
        SPC_ATTR   = 2'b10,
        SPC_IO     = 2'b11
    } space_e;

    // option register layout, msb first
    typedef struct packed {
        logic [SIZE_CODE_W-1:0] size_code;  // [31:27] Gray code of log2(size)
        logic [5:0]             spare_hi;   // [26:21]
        logic [5:0]             strobe;     // [20:15]
        logic [3:0]             setup;      // [14:11]
        logic [3:0]             hold;       // [10:7]
        logic                   wide;       // [6]
        logic                   spare_lo;   // [5]
        space_e                 space;      // [4:3]
        logic                   slot;       // [2]
        logic                   wprot;      // [1]
        logic                   valid;      // [0]
    } opt_t;

    typedef struct packed {
        logic [5:0] strobe;
        logic [3:0] setup;
        logic [3:0] hold;
    } timing_t;

    function automatic logic [SIZE_CODE_W-1:0] gray_to_log2(input logic [SIZE_CODE_W-1:0] g);
        logic [SIZE_CODE_W-1:0] b;
        b[SIZE_CODE_W-1] = g[SIZE_CODE_W-1];
        for (int i = SIZE_CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic space_e space_norm(input space_e s);
        return (s == SPC_ALIAS) ? SPC_COMMON : s;
    endfunction

endpackage

// File: rtl/cwd_win_regs.sv
module cwd_win_regs
    import cwd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic                           sel_opt,
    input  logic [IDX_W-1:0]               idx,
    input  logic [OPT_W-1:0]               wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0] base_o,
    output opt_t [NUM_WIN-1:0]             opt_o
);

    typedef struct packed {
        logic [NUM_WIN-1:0][ADDR_W-1:0] base;
        opt_t [NUM_WIN-1:0]             opt;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we && (int'(idx) < NUM_WIN)) begin
            if (sel_opt) begin
                bank_d.opt[idx] = opt_t'(wdata);
            end else begin
                bank_d.base[idx] = wdata[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign base_o = bank_q.base;
    assign opt_o  = bank_q.opt;

endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match
    import cwd_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int MEM_ALIGN_LOG2 = 12,
    parameter int IO_MAX_LOG2    = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  opt_t              opt,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    localparam int LOG2_LIMIT = (ADDR_W - 1 < MAX_LOG2) ? ADDR_W - 1 : MAX_LOG2;

    logic [SIZE_CODE_W-1:0] lg;
    logic                   code_ok;
    logic                   size_ok;
    logic                   align_ok;
    logic                   enabled;
    logic [ADDR_W:0]        diff;
    logic [ADDR_W-1:0]      above;

    always_comb begin
        lg       = gray_to_log2(opt.size_code);
        code_ok  = (int'(lg) <= LOG2_LIMIT);
        size_ok  = (opt.space != SPC_IO) || (int'(lg) <= IO_MAX_LOG2);
        align_ok = (opt.space == SPC_IO) || (base[MEM_ALIGN_LOG2-1:0] == '0);
        enabled  = opt.valid && code_ok && size_ok && align_ok;
        diff     = {1'b0, addr} - {1'b0, base};
        above    = diff[ADDR_W-1:0] >> lg;
        hit      = enabled && !diff[ADDR_W] && (above == '0);
        offset   = diff[ADDR_W-1:0];
    end

endmodule

// File: rtl/cwd_win_prio.sv
module cwd_win_prio #(
    parameter int NUM_WIN = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = |hits;
        idx   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/card_win_decoder.sv
module card_win_decoder
    import cwd_pkg::*;
#(
    parameter int  NUM_WIN        = 8,
    parameter int  ADDR_W         = 32,
    parameter int  MEM_ALIGN_LOG2 = 12,
    parameter int  IO_MAX_LOG2    = 16,
    localparam int IDX_W          = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel_opt,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              acc_valid,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [ADDR_W-1:0] acc_offset,
    output logic              acc_slot,
    output logic [1:0]        acc_space,
    output logic              acc_wide,
    output logic [3:0]        acc_hold,
    output logic [3:0]        acc_setup,
    output logic [5:0]        acc_strobe,
    output logic              wp_err
);

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] offset;
        logic              slot;
        space_e            space;
        logic              wide;
        timing_t           timing;
    } out_t;

    logic [NUM_WIN-1:0][ADDR_W-1:0] base_w;
    opt_t [NUM_WIN-1:0]             opt_w;
    logic [NUM_WIN-1:0]             hits;
    logic [NUM_WIN-1:0][ADDR_W-1:0] offs;
    logic                           found;
    logic [IDX_W-1:0]               win_idx;
    opt_t                           sel;
    out_t                           out_d, out_q;

    cwd_win_regs #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel_opt (cfg_sel_opt),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .base_o  (base_w),
        .opt_o   (opt_w)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        cwd_win_match #(
            .ADDR_W         (ADDR_W),
            .MEM_ALIGN_LOG2 (MEM_ALIGN_LOG2),
            .IO_MAX_LOG2    (IO_MAX_LOG2)
        ) u_match (
            .base   (base_w[w]),
            .opt    (opt_w[w]),
            .addr   (req_addr),
            .hit    (hits[w]),
            .offset (offs[w])
        );
    end

    cwd_win_prio #(
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W)
    ) u_prio (
        .hits  (hits),
        .found (found),
        .idx   (win_idx)
    );

    always_comb begin
        out_d = '0;
        sel   = opt_w[win_idx];
        if (req_valid && found) begin
            if (req_write && sel.wprot) begin
                out_d.err = 1'b1;
            end else begin
                out_d.valid         = 1'b1;
                out_d.idx           = win_idx;
                out_d.offset        = offs[win_idx];
                out_d.slot          = sel.slot;
                out_d.space         = space_norm(sel.space);
                out_d.wide          = sel.wide;
                out_d.timing.strobe = sel.strobe;
                out_d.timing.setup  = sel.setup;
                out_d.timing.hold   = sel.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign acc_valid  = out_q.valid;
    assign wp_err     = out_q.err;
    assign acc_idx    = out_q.idx;
    assign acc_offset = out_q.offset;
    assign acc_slot   = out_q.slot;
    assign acc_space  = out_q.space;
    assign acc_wide   = out_q.wide;
    assign acc_hold   = out_q.timing.hold;
    assign acc_setup  = out_q.timing.setup;
    assign acc_strobe = out_q.timing.strobe;

endmodule

// File: rtl/card_win_decoder_chk.sv
module card_win_decoder_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_offset,
    input logic [1:0]        acc_space,
    input logic              wp_err
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!acc_valid && !wp_err));

    assert_offset_le_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_offset <= $past(req_addr)));

    assert_space_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_space != 2'b01));

    assert_io_offset_small_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_space == 2'b11) |-> ((acc_offset >> 16) == '0));

    assert_wp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && wp_err));

    assert_wp_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wp_err |-> $past(req_valid && req_write));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!acc_valid && !wp_err));

endmodule

bind card_win_decoder card_win_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .acc_valid  (acc_valid),
    .acc_offset (acc_offset),
    .acc_space  (acc_space),
    .wp_err     (wp_err)
);

// File: tb/card_win_decoder_bench.sv
module card_win_decoder_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic        hit;
        logic [2:0]  idx;
        logic [31:0] off;
        logic        err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h1000_0000, 1'b1, 3'd0, 32'h0000_0000, 1'b0},
        '{1'b0, 32'h13FF_FFFF, 1'b1, 3'd0, 32'h03FF_FFFF, 1'b0},
        '{1'b0, 32'h1400_0000, 1'b1, 3'd1, 32'h0000_0000, 1'b0},
        '{1'b1, 32'h1400_0004, 1'b0, 3'd0, 32'h0000_0000, 1'b1},
        '{1'b0, 32'h1400_0FFF, 1'b1, 3'd1, 32'h0000_0FFF, 1'b0},
        '{1'b0, 32'h1400_1000, 1'b0, 3'd0, 32'h0000_0000, 1'b0},
        '{1'b0, 32'h0000_2010, 1'b1, 3'd2, 32'h0000_0000, 1'b0},
        '{1'b0, 32'h0000_210F, 1'b1, 3'd2, 32'h0000_00FF, 1'b0},
        '{1'b0, 32'h0000_200F, 1'b0, 3'd0, 32'h0000_0000, 1'b0},
        '{1'b0, 32'h3000_0900, 1'b0, 3'd0, 32'h0000_0000, 1'b0},
        '{1'b0, 32'h4000_0010, 1'b0, 3'd0, 32'h0000_0000, 1'b0},
        '{1'b0, 32'h5000_0000, 1'b0, 3'd0, 32'h0000_0000, 1'b0},
        '{1'b0, 32'h6000_0000, 1'b0, 3'd0, 32'h0000_0000, 1'b0},
        '{1'b1, 32'h1000_0040, 1'b1, 3'd0, 32'h0000_0040, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel_opt = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        acc_valid;
    logic [2:0]  acc_idx;
    logic [31:0] acc_offset;
    logic        acc_slot;
    logic [1:0]  acc_space;
    logic        acc_wide;
    logic [3:0]  acc_hold;
    logic [3:0]  acc_setup;
    logic [5:0]  acc_strobe;
    logic        wp_err;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    card_win_decoder u_card_win_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel_opt (cfg_sel_opt),
        .cfg_idx     (cfg_idx),
        .cfg_wdata   (cfg_wdata),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .acc_valid   (acc_valid),
        .acc_idx     (acc_idx),
        .acc_offset  (acc_offset),
        .acc_slot    (acc_slot),
        .acc_space   (acc_space),
        .acc_wide    (acc_wide),
        .acc_hold    (acc_hold),
        .acc_setup   (acc_setup),
        .acc_strobe  (acc_strobe),
        .wp_err      (wp_err)
    );

    function automatic logic [4:0] gcode(input int lg);
        logic [4:0] n;
        n = 5'(lg);
        return n ^ (n >> 1);
    endfunction

    function automatic logic [31:0] mk_opt(input logic v, input logic wp, input logic slot,
                                           input logic [1:0] sp, input logic wide,
                                           input logic [3:0] hold, input logic [3:0] setup,
                                           input logic [5:0] strobe, input logic [4:0] code);
        return {code, 6'b0, strobe, setup, hold, wide, 1'b0, sp, slot, wp, v};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic opt, input int idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we      = 1'b1;
        cfg_sel_opt = opt;
        cfg_idx     = 3'(idx);
        cfg_wdata   = data;
        @(negedge clk);
        cfg_we      = 1'b0;
    endtask

    task automatic do_req(input logic wr, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 64'(acc_valid), 64'd0);
        chk("R1 err after reset", 64'(wp_err), 64'd0);
        do_req(1'b0, 32'h1000_0000);
        chk("R1 unconfigured miss", 64'(acc_valid), 64'd0);

        // window setup
        cfg_write(1'b0, 0, 32'h1000_0000);
        cfg_write(1'b1, 0, mk_opt(1, 0, 0, 2'b00, 1, 4'd1, 4'd2, 6'd5, gcode(26)));
        cfg_write(1'b0, 1, 32'h1400_0000);
        cfg_write(1'b1, 1, mk_opt(1, 1, 0, 2'b10, 1, 4'd0, 4'd0, 6'd3, gcode(12)));
        cfg_write(1'b0, 2, 32'h0000_2010);
        cfg_write(1'b1, 2, mk_opt(1, 0, 1, 2'b11, 0, 4'd2, 4'd1, 6'd4, gcode(8)));
        cfg_write(1'b0, 3, 32'h1000_0000);
        cfg_write(1'b1, 3, mk_opt(1, 0, 0, 2'b00, 0, 4'd0, 4'd0, 6'd1, gcode(12)));
        cfg_write(1'b0, 4, 32'h3000_0800);
        cfg_write(1'b1, 4, mk_opt(1, 0, 0, 2'b00, 0, 4'd0, 4'd0, 6'd1, gcode(11)));
        cfg_write(1'b0, 5, 32'h4000_0000);
        cfg_write(1'b1, 5, mk_opt(1, 0, 1, 2'b11, 0, 4'd0, 4'd0, 6'd1, gcode(17)));
        cfg_write(1'b0, 6, 32'h5000_0000);
        cfg_write(1'b1, 6, mk_opt(1, 0, 0, 2'b00, 0, 4'd0, 4'd0, 6'd1, 5'd16));
        cfg_write(1'b0, 7, 32'h6000_0000);
        cfg_write(1'b1, 7, mk_opt(0, 0, 0, 2'b00, 0, 4'd0, 4'd0, 6'd1, gcode(12)));

        // vector table: R2 hits, R4/R5/R6/R7 disabled windows, R8 overlap, R9 protection
        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].wr, VECS[i].addr);
            chk($sformatf("R2 vec%0d valid", i), 64'(acc_valid), 64'(VECS[i].hit));
            chk($sformatf("R9 vec%0d err", i), 64'(wp_err), 64'(VECS[i].err));
            if (VECS[i].hit) begin
                chk($sformatf("R8 vec%0d idx", i), 64'(acc_idx), 64'(VECS[i].idx));
                chk($sformatf("R2 vec%0d offset", i), 64'(acc_offset), 64'(VECS[i].off));
            end
        end

        // R3 field decoding
        do_req(1'b0, 32'h1000_0010);
        chk("R3 w0 slot", 64'(acc_slot), 64'd0);
        chk("R3 w0 space", 64'(acc_space), 64'd0);
        chk("R3 w0 wide", 64'(acc_wide), 64'd1);
        chk("R3 w0 hold", 64'(acc_hold), 64'd1);
        chk("R3 w0 setup", 64'(acc_setup), 64'd2);
        chk("R3 w0 strobe", 64'(acc_strobe), 64'd5);
        do_req(1'b0, 32'h1400_0010);
        chk("R3 w1 space attr", 64'(acc_space), 64'd2);
        do_req(1'b0, 32'h0000_2020);
        chk("R3 w2 slot", 64'(acc_slot), 64'd1);
        chk("R3 w2 space io", 64'(acc_space), 64'd3);
        chk("R3 w2 wide", 64'(acc_wide), 64'd0);
        chk("R3 w2 timing", 64'({acc_hold, acc_setup, acc_strobe}), 64'({4'd2, 4'd1, 6'd4}));

        // R2 strobe lasts one cycle; R11 idle cycle with a matching address
        do_req(1'b0, 32'h1000_0020);
        chk("R2 strobe high", 64'(acc_valid), 64'd1);
        req_addr = 32'h1000_0020;
        @(negedge clk);
        chk("R2 strobe one cycle", 64'(acc_valid), 64'd0);
        chk("R11 idle no err", 64'(wp_err), 64'd0);

        // R10 config write alongside a request to the same window
        @(negedge clk);
        cfg_we      = 1'b1;
        cfg_sel_opt = 1'b1;
        cfg_idx     = 3'd2;
        cfg_wdata   = 32'h0;
        req_valid   = 1'b1;
        req_write   = 1'b0;
        req_addr    = 32'h0000_2010;
        @(negedge clk);
        cfg_we      = 1'b0;
        req_valid   = 1'b0;
        chk("R10 old settings hit", 64'(acc_valid), 64'd1);
        chk("R10 old settings idx", 64'(acc_idx), 64'd2);
        do_req(1'b0, 32'h0000_2010);
        chk("R10 R5 new settings miss", 64'(acc_valid), 64'd0);

        // R3 space 01 reported as common
        cfg_write(1'b1, 7, mk_opt(1, 0, 0, 2'b01, 0, 4'd0, 4'd0, 6'd1, gcode(12)));
        do_req(1'b0, 32'h6000_0004);
        chk("R3 alias hit", 64'(acc_valid), 64'd1);
        chk("R3 alias space", 64'(acc_space), 64'd0);

        // R8 overlap between window 3 and window 7
        cfg_write(1'b0, 3, 32'h7000_0000);
        cfg_write(1'b0, 7, 32'h7000_0000);
        cfg_write(1'b1, 7, mk_opt(1, 0, 0, 2'b00, 0, 4'd0, 4'd0, 6'd1, gcode(16)));
        do_req(1'b0, 32'h7000_0010);
        chk("R8 lower wins", 64'(acc_idx), 64'd3);
        do_req(1'b0, 32'h7000_2000);
        chk("R8 upper alone idx", 64'(acc_idx), 64'd7);
        chk("R8 upper alone offset", 64'(acc_offset), 64'h2000);

        // R7 I/O window at the 64 KB limit
        cfg_write(1'b1, 5, mk_opt(1, 0, 1, 2'b11, 0, 4'd0, 4'd0, 6'd1, gcode(16)));
        do_req(1'b0, 32'h4000_FFFF);
        chk("R7 io edge hit", 64'(acc_valid), 64'd1);
        chk("R7 io edge offset", 64'(acc_offset), 64'hFFFF);
        do_req(1'b0, 32'h4001_0000);
        chk("R7 io past end", 64'(acc_valid), 64'd0);

        // R6 aligned base enables window 4
        cfg_write(1'b0, 4, 32'h3000_1000);
        do_req(1'b0, 32'h3000_1100);
        chk("R6 aligned hit", 64'(acc_valid), 64'd1);
        chk("R6 aligned offset", 64'(acc_offset), 64'h100);

        // R4 largest legal code at the window end
        do_req(1'b0, 32'h1400_0000 - 32'd1);
        chk("R4 64MB last byte idx", 64'(acc_idx), 64'd0);

        finish_run();
    end

endmodule